// File: doc/BRIEF.md
# Indirect Register Access Window

This block lets a host reach an extended register space through only two directly mapped host registers. One is an address pointer into a 16-bit, byte-addressed indirect space. The other is a 32-bit data window onto the quadlet that the pointer currently selects. The host loads the pointer once. After that, each read or write of the window moves the pointer forward by one quadlet. A run of consecutive quadlets therefore needs only a single pointer load.

The indirect space holds a bank of sixty-four 32-bit FIFO-size registers at indirect addresses 0x100 to 0x1FC. All other indirect locations are reserved: they read as zero and ignore writes. The host side is a plain synchronous strobe interface. One access is accepted on every cycle in which `host_req` is high. There is no back-pressure, because the block can always take an access. Read data comes back registered, one cycle after the read strobe, and `host_rvalid` marks that cycle. Nothing ever stalls, so the host must not expect a ready signal.

Top module: `indirect_window`

## Requirements
- R1: Only host address 0x1F8 (bit 8 set, low byte 0xF8) selects the pointer, and only 0x1FC selects the window. Any other host address, including 0x0F8 with bit 8 clear, reads as 0 and does not change the pointer.
- R2: A write to the pointer stores wdata bits 15..2, forces bits 1..0 to zero and discards bits 31..16. A pointer read returns the pointer zero-extended to 32 bits.
- R3: A window read returns the full 32-bit content of the quadlet that the pointer selects at the time of the strobe.
- R4: Every window access, read or write, adds 4 to the pointer after the access. 0xFFFC wraps to 0x0000.
- R5: Indirect addresses 0x100..0x1FC hold 64 independent 32-bit FIFO-size registers, with index (address-0x100)/4, written and read through the window.
- R6: Window reads of reserved indirect addresses (0x000..0x0FC and 0x200..0xFFFC) return 0. Window writes to them change no stored register, but they still advance the pointer.
- R7: After reset the pointer is 0, all size registers are 0 and `host_rvalid` is low.
- R8: `host_rvalid` is high exactly in the cycle after an accepted read strobe, with `host_rdata` valid in that cycle. Accesses may be issued on every cycle without back-pressure.
- R9: A pointer write is used by the very next window access, even when that access comes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read (qualified by host_req) |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid when host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
The assertions check the following on every cycle: pointer alignment, the +4 step after each window access, that the pointer holds when it is not loaded or stepped, the read-valid timing, and that reads of the pointer, of reserved window locations and of foreign host addresses return the expected values. Only the bench scenarios can show the rest. That covers the true content of the size bank after burst writes, that reserved writes leave the bank intact, the wrap from 0xFFFC to zero after a full sweep of the indirect space, and the back-to-back use of a freshly loaded pointer.

// File: rtl/ind_pkg.sv
package ind_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PTR   = 2'd1,
    ACC_WIN   = 2'd2,
    ACC_OTHER = 2'd3
  } acc_kind_e;

  localparam int QUAD_BYTES = 4;
endpackage

// File: rtl/ind_host_decode.sv
module ind_host_decode #(
  parameter int                  HADDR_W = 9,
  parameter logic [HADDR_W-1:0]  PTR_OFS = 9'h1F8,
  parameter logic [HADDR_W-1:0]  WIN_OFS = 9'h1FC
) (
  input  logic                 req,
  input  logic [HADDR_W-1:0]   addr,
  output ind_pkg::acc_kind_e   kind
);
  always_comb begin
    if (!req)                 kind = ind_pkg::ACC_NONE;
    else if (addr == PTR_OFS) kind = ind_pkg::ACC_PTR;
    else if (addr == WIN_OFS) kind = ind_pkg::ACC_WIN;
    else                      kind = ind_pkg::ACC_OTHER;
  end
endmodule

// File: rtl/ind_pointer.sv
module ind_pointer #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr
);
  localparam int AL = $clog2(ind_pkg::QUAD_BYTES);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(ind_pkg::QUAD_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= {load_val[PTR_W-1:AL], {AL{1'b0}}};
    else if (step) ptr <= ptr + STEP;
  end
endmodule

// File: rtl/ind_region_decode.sv
module ind_region_decode #(
  parameter int               PTR_W = 16,
  parameter logic [PTR_W-1:0] BASE  = 16'h0100,
  parameter int               COUNT = 64,
  localparam int              IW    = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             hit,
  output logic [IW-1:0]    idx
);
  localparam int AL = $clog2(ind_pkg::QUAD_BYTES);
  localparam logic [PTR_W:0] LIMIT = {1'b0, BASE} + (PTR_W+1)'(COUNT * ind_pkg::QUAD_BYTES);

  logic [PTR_W-1:0] rel;

  always_comb begin
    rel = ptr - BASE;
    hit = (ptr >= BASE) && ({1'b0, ptr} < LIMIT);
    idx = rel[AL +: IW];
  end
endmodule

// File: rtl/ind_size_bank.sv
module ind_size_bank #(
  parameter int  DATA_W = 32,
  parameter int  COUNT  = 64,
  localparam int IW     = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [COUNT];

  for (genvar g = 0; g < COUNT; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                           regs[g] <= '0;
      else if (we && (idx == IW'(g)))       regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < COUNT; k++)
      if (idx == IW'(k)) rdata = regs[k];
  end
endmodule

// File: rtl/indirect_window.sv
module indirect_window #(
  parameter int                 HADDR_W    = 9,
  parameter int                 DATA_W     = 32,
  parameter int                 PTR_W      = 16,
  parameter logic [HADDR_W-1:0] PTR_OFS    = 9'h1F8,
  parameter logic [HADDR_W-1:0] WIN_OFS    = 9'h1FC,
  parameter logic [PTR_W-1:0]   SIZE_BASE  = 16'h0100,
  parameter int                 SIZE_COUNT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid
);
  localparam int IW = (SIZE_COUNT > 1) ? $clog2(SIZE_COUNT) : 1;

  ind_pkg::acc_kind_e kind;
  logic [PTR_W-1:0]  ptr_q;
  logic              ptr_ld;
  logic              win_acc;
  logic              size_hit;
  logic [IW-1:0]     size_idx;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] rd_next;
  logic              rd_acc;

  ind_host_decode #(.HADDR_W(HADDR_W), .PTR_OFS(PTR_OFS), .WIN_OFS(WIN_OFS)) u_dec (
    .req(host_req), .addr(host_addr), .kind(kind)
  );

  assign ptr_ld  = (kind == ind_pkg::ACC_PTR) && host_we;
  assign win_acc = (kind == ind_pkg::ACC_WIN);
  assign rd_acc  = host_req && !host_we;

  ind_pointer #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_ld), .load_val(host_wdata),
    .step(win_acc), .ptr(ptr_q)
  );

  ind_region_decode #(.PTR_W(PTR_W), .BASE(SIZE_BASE), .COUNT(SIZE_COUNT)) u_reg (
    .ptr(ptr_q), .hit(size_hit), .idx(size_idx)
  );

  ind_size_bank #(.DATA_W(DATA_W), .COUNT(SIZE_COUNT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(win_acc && host_we && size_hit),
    .idx(size_idx), .wdata(host_wdata), .rdata(bank_rd)
  );

  always_comb begin
    unique case (kind)
      ind_pkg::ACC_PTR: rd_next = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
      ind_pkg::ACC_WIN: rd_next = size_hit ? bank_rd : '0;
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_acc;
      if (rd_acc) host_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/ind_window_chk.sv
module ind_window_chk #(
  parameter int                 HADDR_W = 9,
  parameter int                 DATA_W  = 32,
  parameter int                 PTR_W   = 16,
  parameter logic [HADDR_W-1:0] PTR_OFS = 9'h1F8,
  parameter logic [HADDR_W-1:0] WIN_OFS = 9'h1FC
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [HADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               host_rvalid,
  input logic [PTR_W-1:0]   ptr,
  input logic               win_acc,
  input logic               ptr_ld,
  input logic               hit
);
  logic rd_ptr, rd_win_res, rd_other;
  assign rd_ptr     = host_req && !host_we && (host_addr == PTR_OFS);
  assign rd_win_res = host_req && !host_we && (host_addr == WIN_OFS) && !hit;
  assign rd_other   = host_req && !host_we && (host_addr != PTR_OFS) && (host_addr != WIN_OFS);

  assert_ptr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[1:0] == 2'b00);

  assert_ptr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr |=> host_rdata == {{(DATA_W-PTR_W){1'b0}}, $past(ptr)});

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_acc |=> ptr == PTR_W'($past(ptr) + PTR_W'(4)));

  assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_acc && !ptr_ld) |=> $stable(ptr));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win_res |=> host_rdata == '0);

  assert_other_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |=> host_rdata == '0);

  assert_rvalid_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);

  assert_rvalid_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid);
endmodule

bind indirect_window ind_window_chk #(
  .HADDR_W(HADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
  .PTR_OFS(PTR_OFS), .WIN_OFS(WIN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .ptr(ptr_q), .win_acc(win_acc), .ptr_ld(ptr_ld), .hit(size_hit)
);

// File: tb/sim_indirect_window.sv
`timescale 1ns/1ps
module sim_indirect_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [8:0] A_PTR = 9'h1F8;
  localparam logic [8:0] A_WIN = 9'h1FC;

  always #2 clk = ~clk;

  indirect_window u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ 32'h0000_5A5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    d = host_rdata;
    if (!host_rvalid) begin
      n_chk++; n_bad++;
      $display("FAIL R8 rvalid actual=0 expected=1");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    check("R7 rvalid after reset", {31'b0, host_rvalid}, 32'd0);
    rd(A_PTR, v); check("R7 pointer reset", v, 32'd0);
    rd(A_WIN, v); check("R7 reserved 0x000 read", v, 32'd0);
    rd(A_PTR, v); check("R4 step after read", v, 32'd4);
    @(negedge clk);
    check("R8 rvalid low when idle", {31'b0, host_rvalid}, 32'd0);

    // R2 pointer write masking
    wr(A_PTR, 32'hABCD_0107);
    rd(A_PTR, v); check("R2 pointer mask", v, 32'h0000_0104);

    // R1 foreign addresses
    wr(9'h0F8, 32'h0000_0180);
    wr(9'h0FC, 32'h1234_5678);
    rd(A_PTR, v); check("R1 foreign write ignored", v, 32'h0000_0104);
    rd(9'h0F8, v); check("R1 foreign read 0x0F8", v, 32'd0);
    rd(9'h000, v); check("R1 foreign read 0x000", v, 32'd0);

    // R5 burst write of bank via auto-increment
    wr(A_PTR, 32'h0000_0100);
    for (int i = 0; i < 64; i++) wr(A_WIN, pat(i));
    rd(A_PTR, v); check("R4 pointer after 64 writes", v, 32'h0000_0200);
    wr(A_PTR, 32'h0000_0100);
    for (int i = 0; i < 64; i++) begin
      rd(A_WIN, v); check($sformatf("R5 bank entry %0d", i), v, pat(i));
    end

    // R6 reserved writes ignored but step
    wr(A_PTR, 32'h0000_00FC);
    wr(A_WIN, 32'hDEAD_BEEF);
    rd(A_PTR, v); check("R6 reserved write steps", v, 32'h0000_0100);
    wr(A_PTR, 32'h0000_0200);
    wr(A_WIN, 32'hCAFE_F00D);
    wr(A_PTR, 32'h0000_FFFC);
    wr(A_WIN, 32'h0BAD_0BAD);
    rd(A_PTR, v); check("R4 write wrap", v, 32'd0);
    wr(A_PTR, 32'h0000_00FC);
    rd(A_WIN, v); check("R6 reserved 0x0FC read", v, 32'd0);
    rd(A_WIN, v); check("R6 entry 0 intact", v, pat(0));
    wr(A_PTR, 32'h0000_01FC);
    rd(A_WIN, v); check("R6 entry 63 intact", v, pat(63));
    rd(A_WIN, v); check("R6 reserved 0x200 read", v, 32'd0);

    // R3 R4 R6 full sweep of indirect space
    wr(A_PTR, 32'd0);
    for (int a = 0; a < 65536; a += 4) begin
      rd(A_WIN, v);
      if (a >= 32'h100 && a < 32'h200)
        check($sformatf("R3 sweep 0x%h", a), v, pat((a - 32'h100) / 4));
      else
        check($sformatf("R6 sweep 0x%h", a), v, 32'd0);
    end
    rd(A_PTR, v); check("R4 read wrap to 0", v, 32'd0);

    // R9 back-to-back pointer load then window access
    wr(A_PTR, 32'h0000_01F0);
    rd(A_WIN, v); check("R9 load then read", v, pat(60));
    wr(A_PTR, 32'h0000_0140);
    wr(A_WIN, 32'h7777_0001);
    wr(A_PTR, 32'h0000_0140);
    rd(A_WIN, v); check("R9 load then write", v, 32'h7777_0001);
    rd(A_WIN, v); check("R5 neighbour untouched", v, pat(17));

    // R8 back-to-back reads each valid
    wr(A_PTR, 32'h0000_0100);
    host_req = 1'b1; host_we = 1'b0; host_addr = A_WIN;
    @(negedge clk);
    check("R8 first of pair", host_rdata, pat(0));
    @(negedge clk);
    host_req = 1'b0;
    check("R8 second of pair", host_rdata, pat(1));
    check("R8 rvalid on pair", {31'b0, host_rvalid}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule